// File: doc/BRIEF.md
# Gated Clock Frequency Meter

The meter estimates the rate of one clock chosen from a bank of up to 128 candidate clocks. It opens a gate window whose length is a whole number of microseconds, timed by a 1 MHz reference tick. While the window is open it counts rising edges of the chosen clock. The count then goes back to the register clock domain, where software reads it. For a 64 µs window, software adds 31 to the count and shifts right by 6, which gives the rate in MHz rounded to the nearest whole value.

A single 32-bit control word holds every setting: window length, run, repeat, interrupt enable, count enable and source index. Bit 31 of the readback is a busy flag. The result appears on a separate 32-bit read port.

The window is opened and closed in the register domain. A two-flop synchronizer carries it into the measured clock's domain. The finished count comes back through a four-phase request/acknowledge handshake.

Top module: `freq_meter`

## Requirements
- R1: Control bits [15:0] hold N. The window opens on the first reference tick after a start and closes N+1 ticks later, so the count lies within 2 of f_MHz × (N+1).
- R2: Writing bit 16 as 1 while it is 0 starts a measurement, and busy (readback bit 31) reads 1 from the next cycle. Writing bit 16 as 0 aborts at once: busy drops and no result is captured.
- R3: With bit 17 clear, busy drops when the result is captured. No further result is captured until a new start.
- R4: With bit 18 set, the irq output rises when a result is captured. With bit 18 clear it stays low. Any control write clears irq, but a capture in the same cycle as a write leaves irq set.
- R5: With bit 19 clear, no edges are counted and the captured result is 0.
- R6: Bits [26:20] give an index from 0 to 127 that selects src_clk[index] as the measured clock.
- R7: With bit 17 set, every capture starts a new window. Busy stays 1 and each window yields a new result and a new irq.
- R8: The edge count saturates at 0xFFFFF and does not wrap.
- R9: Writing 0 to the control word returns the block to idle: readback 0, busy 0, irq 0, result 0.
- R10: result_rd bits [19:0] hold the count and bits [31:20] read 0. For a 64 µs window, (count+31)>>6 equals the rate in MHz.
- R11: Readback bits [26:0] return the last written values, and bits [30:27] read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and gate-timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle 1 MHz reference pulse, in the clk domain |
| src_clk | input | NSRC | Bank of candidate clocks |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| ctrl_rd | output | 32 | Control readback with busy in bit 31 |
| result_rd | output | 32 | Captured edge count |
| irq | output | 1 | Completion interrupt, a level held until the next control write |

## Verification
A result capture and a control write can land on the same clock edge. When they do, the write clears irq while the capture sets it.

The bench provokes this in repeat mode with a one-microsecond window. It holds the write strobe high on every cycle, rewriting the same control value across several window ends, so each capture is certain to meet a write.

The check passes only if irq is seen high in at least one cycle, which shows the capture took priority, while busy stays 1 and the count still matches the selected clock's rate.

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int NSRC  = 128,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [NSRC-1:0]  src_clk,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      ctrl_rd,
  output logic [31:0]      result_rd,
  output logic             irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_OPEN, S_WAIT} st_t;

  logic [15:0]      win_len, tcnt;
  logic             run, cont, irq_en, cnt_en, busy, win;
  logic [6:0]       sel;
  logic [CNT_W-1:0] result;
  st_t              st;
  logic             req_s1, req_s2, req_s3;

  logic             g1, g2, g3, e1, e2, ack_s1, ack_s2, req_m;
  logic [CNT_W-1:0] cnt_m, hold_m;

  wire meas_clk = src_clk[sel];
  wire wr_zero  = wr_en && (wr_data == 32'd0);
  wire wr_stop  = wr_en && !wr_data[16];
  wire wr_start = wr_en && wr_data[16] && !run;
  wire cap      = (st == S_WAIT) && req_s2 && !req_s3;
  wire ack      = req_s2;

  assign ctrl_rd   = {busy, 4'b0, sel, cnt_en, irq_en, cont, run, win_len};
  assign result_rd = {{(32-CNT_W){1'b0}}, result};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_len <= '0; run <= 1'b0; cont <= 1'b0; irq_en <= 1'b0;
      cnt_en <= 1'b0; sel <= '0; busy <= 1'b0; irq <= 1'b0;
      win <= 1'b0; tcnt <= '0; result <= '0; st <= S_IDLE;
      req_s1 <= 1'b0; req_s2 <= 1'b0; req_s3 <= 1'b0;
    end else begin
      req_s1 <= req_m; req_s2 <= req_s1; req_s3 <= req_s2;
      if (wr_en) begin
        win_len <= wr_data[15:0];
        run     <= wr_data[16];
        cont    <= wr_data[17];
        irq_en  <= wr_data[18];
        cnt_en  <= wr_data[19];
        sel     <= wr_data[26:20];
        irq     <= 1'b0;
      end
      if (wr_zero) result <= '0;
      if (wr_stop) begin
        st <= S_IDLE; busy <= 1'b0; win <= 1'b0;
      end else if (wr_start) begin
        st <= S_ARM; busy <= 1'b1; win <= 1'b0;
      end else begin
        case (st)
          S_ARM: if (ref_tick) begin
            win <= 1'b1; tcnt <= '0; st <= S_OPEN;
          end
          S_OPEN: if (ref_tick) begin
            if (tcnt == win_len) begin
              win <= 1'b0; st <= S_WAIT;
            end else tcnt <= tcnt + 16'd1;
          end
          S_WAIT: if (cap) begin
            result <= hold_m;
            if (irq_en) irq <= 1'b1;
            if (cont) st <= S_ARM;
            else begin st <= S_IDLE; busy <= 1'b0; end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) begin
      g1 <= 1'b0; g2 <= 1'b0; g3 <= 1'b0; e1 <= 1'b0; e2 <= 1'b0;
      ack_s1 <= 1'b0; ack_s2 <= 1'b0; req_m <= 1'b0;
      cnt_m <= '0; hold_m <= '0;
    end else begin
      g1 <= win; g2 <= g1; g3 <= g2;
      e1 <= cnt_en; e2 <= e1;
      ack_s1 <= ack; ack_s2 <= ack_s1;
      if (g2 && !g3) cnt_m <= '0;
      else if (g2 && e2 && cnt_m != CNT_MAX) cnt_m <= cnt_m + 1'b1;
      if (!g2 && g3) begin
        hold_m <= cnt_m; req_m <= 1'b1;
      end else if (ack_s2) req_m <= 1'b0;
    end
  end

  a_r2_window_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> busy);

  a_r9_zero_write_idles: assert property (@(posedge clk) disable iff (!rst_n)
    wr_zero |=> (ctrl_rd == 32'd0) && !irq && (result_rd == 32'd0));

  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en));

  a_r3_busy_falls_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(wr_en)) |-> !$past(cont));

  a_r1_result_moves_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> ($past(busy) || $past(wr_en)));

  a_r8_count_saturates: assert property (@(posedge meas_clk) disable iff (!rst_n)
    (cnt_m == CNT_MAX && !(g2 && !g3)) |=> (cnt_m == CNT_MAX));

endmodule

// File: tb/tb_freq_meter.sv
`timescale 1ns/1ps
module tb_freq_meter;
  logic         clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, wr_en = 1'b0;
  logic [127:0] src_clk = '0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  ctrl_rd, result_rd;
  logic         irq;
  int checks = 0, fails = 0;

  freq_meter dut (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .src_clk(src_clk),
                  .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
                  .result_rd(result_rd), .irq(irq));

  always #10 clk = ~clk;
  initial forever #0.5  src_clk[0]   = ~src_clk[0];
  initial forever #5    src_clk[5]   = ~src_clk[5];
  initial forever #20   src_clk[77]  = ~src_clk[77];
  initial forever #12.5 src_clk[127] = ~src_clk[127];

  initial forever begin
    repeat (49) @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  end

  initial begin
    #(64'd190000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [31:0] mk(int n, bit r, bit c, bit ie, bit ce, int s);
    return (32'(n) & 32'hFFFF) | (32'(r) << 16) | (32'(c) << 17) | (32'(ie) << 18) |
           (32'(ce) << 19) | ((32'(s) & 32'h7F) << 20);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic near(input string tag, input longint act, input longint exp);
    chk(act >= exp - 2 && act <= exp + 2, tag, act, exp);
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle(input int maxc, input string tag);
    int n = 0;
    while (ctrl_rd[31] && n < maxc) begin @(negedge clk); n++; end
    chk(!ctrl_rd[31], tag, ctrl_rd[31], 0);
  endtask

  task automatic wait_irq(input int maxc, input string tag);
    int n = 0;
    while (!irq && n < maxc) begin @(negedge clk); n++; end
    chk(irq, tag, irq, 1);
  endtask

  task automatic t_reset;
    chk(ctrl_rd == 0, "R9 reset control", ctrl_rd, 0);
    chk(result_rd == 0, "R9 reset result", result_rd, 0);
    chk(!irq, "R4 reset irq", irq, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v = mk(63, 1, 0, 1, 1, 5);
    logic [31:0] r;
    wr(v | 32'hC000_0000);
    chk(ctrl_rd[31], "R2 busy after start", ctrl_rd[31], 1);
    wait_idle(5000, "R3 busy drops oneshot");
    near("R1 count 100MHz 64us", result_rd[19:0], 6400);
    chk(((result_rd[19:0] + 31) >> 6) == 100, "R10 rounded MHz", (result_rd[19:0] + 31) >> 6, 100);
    chk(result_rd[31:20] == 0, "R10 upper bits zero", result_rd[31:20], 0);
    chk(irq, "R4 irq on completion", irq, 1);
    chk(ctrl_rd == v, "R11 readback", ctrl_rd, v);
    r = result_rd;
    repeat (5000) @(negedge clk);
    chk(result_rd == r && !ctrl_rd[31], "R3 no recapture", result_rd, r);
    wr(mk(63, 0, 0, 1, 1, 5));
    chk(!irq, "R4 write clears irq", irq, 0);
  endtask

  task automatic t_index_no_irq;
    wr(mk(63, 1, 0, 0, 1, 127));
    wait_idle(5000, "R6 done idx127");
    near("R6 count 40MHz idx127", result_rd[19:0], 2560);
    chk(((result_rd[19:0] + 31) >> 6) == 40, "R10 rounded 40MHz", (result_rd[19:0] + 31) >> 6, 40);
    chk(!irq, "R4 irq disabled", irq, 0);
    wr(mk(63, 0, 0, 0, 1, 127));
  endtask

  task automatic t_window_len;
    wr(mk(9, 1, 0, 0, 1, 77));
    wait_idle(2000, "R1 done 10us");
    near("R1 count 25MHz 10us", result_rd[19:0], 250);
    wr(mk(9, 0, 0, 0, 1, 77));
  endtask

  task automatic t_no_enable;
    wr(mk(9, 1, 0, 1, 0, 5));
    wait_idle(2000, "R5 done gated");
    chk(result_rd == 0, "R5 nothing counted", result_rd, 0);
    chk(irq, "R5 completion still flagged", irq, 1);
    wr(mk(9, 0, 0, 0, 0, 5));
  endtask

  task automatic t_abort;
    logic [31:0] r = result_rd;
    wr(mk(999, 1, 0, 1, 1, 5));
    repeat (200) @(negedge clk);
    chk(ctrl_rd[31], "R2 busy mid window", ctrl_rd[31], 1);
    wr(mk(999, 0, 0, 1, 1, 5));
    chk(!ctrl_rd[31], "R2 abort drops busy", ctrl_rd[31], 0);
    repeat (3000) @(negedge clk);
    chk(result_rd == r && !irq, "R2 abort no capture", result_rd, r);
  endtask

  task automatic t_continuous;
    logic [31:0] v = mk(9, 1, 1, 1, 1, 77);
    wr(v);
    wait_irq(3000, "R7 first irq");
    near("R7 first result", result_rd[19:0], 250);
    chk(ctrl_rd[31], "R7 busy stays", ctrl_rd[31], 1);
    wr(v);
    chk(!irq, "R4 irq cleared cont", irq, 0);
    wait_irq(3000, "R7 second irq");
    near("R7 second result", result_rd[19:0], 250);
    chk(ctrl_rd[31], "R7 busy still high", ctrl_rd[31], 1);
    wr(mk(9, 0, 1, 1, 1, 77));
    chk(!ctrl_rd[31], "R7 stop continuous", ctrl_rd[31], 0);
  endtask

  task automatic t_collision;
    logic [31:0] v = mk(0, 1, 1, 1, 1, 5);
    int seen = 0;
    bit busy_ok = 1'b1;
    wr(v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) seen++;
      if (!ctrl_rd[31]) busy_ok = 1'b0;
    end
    wr_en = 1'b0;
    chk(seen > 0, "R4 capture beats write clear", seen, 1);
    chk(busy_ok, "R7 busy across hammer", busy_ok, 1);
    near("R1 count 1us window", result_rd[19:0], 100);
    wr(mk(0, 0, 1, 1, 1, 5));
  endtask

  task automatic t_saturate;
    wr(mk(1049, 1, 0, 0, 1, 0));
    wait_idle(60000, "R8 done saturate");
    chk(result_rd == 32'h000F_FFFF, "R8 saturated count", result_rd, 32'hF_FFFF);
    wr(mk(1049, 0, 0, 0, 1, 0));
  endtask

  task automatic t_zero;
    wr(mk(9, 1, 0, 1, 1, 77));
    wait_idle(2000, "R9 done before clear");
    chk(irq && result_rd != 0, "R9 state before clear", result_rd, 250);
    wr(32'd0);
    chk(ctrl_rd == 0, "R9 control cleared", ctrl_rd, 0);
    chk(result_rd == 0, "R9 result cleared", result_rd, 0);
    chk(!irq, "R9 irq cleared", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_oneshot;
    t_index_no_irq;
    t_window_len;
    t_no_enable;
    t_abort;
    t_continuous;
    t_collision;
    t_saturate;
    t_zero;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule